// File: doc/BRIEF.md
# Write-Once Timing Clock Divider for a Nonvolatile Memory Controller

This block holds the one control register that sets the timing clock of a nonvolatile memory controller, and it derives that clock from the bus clock. Software programs a divisor and a prescale choice through a simple register port, and reads them back at any time. The derived clock leaves the block as a one-bus-cycle enable strobe, so the erase and program sequencers downstream can count whole timing pulses without a second clock domain.

The register can be configured only once after reset. The first write after reset captures the divisor and prescale bits and raises a read-only loaded flag. That flag also releases the counters and enables erase and program operations. Every later write is ignored. The divided rate is the bus rate divided by (N+1), or by 8·(N+1) when the prescaler is selected.

Top module: `nvmClockDivider`

## Requirements
- R1: After reset, rdData reads 0x00, tickStb is 0 and progEnable is 0.
- R2: Bit 7 of rdData is the loaded flag. The first write after reset sets it, whatever value wrData[7] carries.
- R3: Bits 6:0 take the value of the first write after reset. Any later write leaves all eight bits of rdData unchanged and does not disturb the strobe sequence.
- R4: rdData always returns {loaded flag, stored bits 6:0}. Bit 6 is the prescale select and bits 5:0 are the divisor N.
- R5: With bit 6 = 0 and N > 0, tickStb is high for exactly one bus cycle in every N+1 bus cycles.
- R6: With bit 6 = 1, tickStb is high for exactly one bus cycle in every 8·(N+1) bus cycles.
- R7: While the loaded flag is 0, tickStb stays 0. Counting starts from zero in the first cycle in which the flag reads 1, so the first strobe falls P−1 cycles later, where P is the strobe period.
- R8: progEnable is 0 while the loaded flag is 0 and 1 once it is set.
- R9: With bit 6 = 0 and N = 0, tickStb is high in every bus cycle once the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one bus cycle per write |
| wrData | input | 8 | Write data: bit 6 prescale select, bits 5:0 divisor N, bit 7 ignored |
| rdData | output | 8 | Register read value: {loaded, prescale, N} |
| tickStb | output | 1 | One-bus-cycle enable at the divided timing rate |
| loaded | output | 1 | Loaded flag, set by the first write |
| progEnable | output | 1 | Allows erase and program operations |

## Verification
A wrong counter state shows up at tickStb: the strobe lands in the wrong cycle, and the error persists for the whole period that follows. An early or late count therefore appears within one period of P bus cycles. A lock fault shows up at rdData in the cycle after the offending write, and it also shifts the strobe phase on the next period. The bench sweeps every divisor value with both prescale settings, checking the phase of the first strobe and three whole periods after it for each.

// File: rtl/nvmDivPkg.sv
package nvmDivPkg;
  // Strobes from the register control to the divider datapath
  typedef struct packed {
    logic run;      // counters may advance
    logic restart;  // force counters to zero this cycle
  } divCtlT;
endpackage

// File: rtl/nvmDivCtrl.sv
module nvmDivCtrl
  import nvmDivPkg::*;
#(
  parameter int DIV_W = 6,
  localparam int REG_W = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             loaded,
  output logic             prescaleSel,
  output logic [DIV_W-1:0] divisor,
  output divCtlT           ctl
);
  localparam int CFG_W = REG_W - 1;

  logic [CFG_W-1:0] cfgBits;
  logic             loadEvent;

  // only the first write after reset is accepted
  assign loadEvent = wrEn && !loaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBits <= '0;
      loaded  <= 1'b0;
    end else if (loadEvent) begin
      cfgBits <= wrData[CFG_W-1:0];
      loaded  <= 1'b1;
    end
  end

  assign rdData      = {loaded, cfgBits};
  assign prescaleSel = cfgBits[DIV_W];
  assign divisor     = cfgBits[DIV_W-1:0];
  assign ctl.run     = loaded;
  assign ctl.restart = loadEvent;

  p_lock_r3: assert property (@(posedge clk) disable iff (!rstN)
    loaded |=> $stable(cfgBits));
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    loaded |=> loaded);
  p_first_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !loaded) |=> (loaded && cfgBits == $past(wrData[CFG_W-1:0])));
  p_no_spurious_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !loaded) |=> !loaded);
endmodule

// File: rtl/nvmDivData.sv
module nvmDivData
  import nvmDivPkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int PRE_RATIO = 8,
  localparam int PRE_W    = (PRE_RATIO > 1) ? $clog2(PRE_RATIO) : 1,
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(PRE_RATIO - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtlT           ctl,
  input  logic             prescaleSel,
  input  logic [DIV_W-1:0] divisor,
  output logic             tickStb
);
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic             preTick;
  logic             divWrap;

  assign preTick = !prescaleSel || (preCnt == PRE_MAX);
  assign divWrap = (divCnt == divisor);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (!ctl.run || ctl.restart) begin
      preCnt <= '0;
      divCnt <= '0;
    end else begin
      if (prescaleSel)
        preCnt <= (preCnt == PRE_MAX) ? '0 : preCnt + 1'b1;
      if (preTick)
        divCnt <= divWrap ? '0 : divCnt + 1'b1;
    end
  end

  assign tickStb = ctl.run && preTick && divWrap;

  p_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> (preCnt == '0 && divCnt == '0));
  p_div_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (divCnt <= divisor));
  p_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickStb && divisor != '0) |=> !tickStb);
  p_pre_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickStb && prescaleSel) |=> !tickStb);
  p_pre_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !prescaleSel |-> (preCnt == '0));
endmodule

// File: rtl/nvmClockDivider.sv
module nvmClockDivider
  import nvmDivPkg::*;
#(
  parameter int DIV_W     = 6,
  parameter int PRE_RATIO = 8,
  localparam int REG_W    = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             tickStb,
  output logic             loaded,
  output logic             progEnable
);
  divCtlT           ctl;
  logic             prescaleSel;
  logic [DIV_W-1:0] divisor;

  nvmDivCtrl #(.DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .loaded(loaded), .prescaleSel(prescaleSel),
    .divisor(divisor), .ctl(ctl)
  );

  nvmDivData #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .prescaleSel(prescaleSel),
    .divisor(divisor), .tickStb(tickStb)
  );

  assign progEnable = loaded;

  p_prog_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[REG_W-1] |-> (!progEnable && !tickStb));
  p_prog_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !progEnable) |=> progEnable);
endmodule

// File: tb/test_nvmClockDivider.sv
`timescale 1ns/1ps
module test_nvmClockDivider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       tickStb, loaded, progEnable;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  nvmClockDivider i_nvmClockDivider (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .tickStb(tickStb), .loaded(loaded), .progEnable(progEnable)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCfg(input int pre, input int n);
    logic [7:0] data;
    logic [7:0] expRd;
    int period, bad, badCycle, badVal;
    rstN = 1'b0; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    check(rdData == 8'h00, "R1 rdData", rdData, 0);
    check(tickStb == 1'b0, "R1 tickStb", tickStb, 0);
    check(progEnable == 1'b0, "R1/R8 progEnable", progEnable, 0);
    rstN = 1'b1;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (tickStb || progEnable || rdData != 8'h00) bad++;
    end
    check(bad == 0, "R7/R8 idle before load", bad, 0);
    data = {n[0], pre[0], n[5:0]};          // bit 7 toggles across configs (R2)
    expRd = {1'b1, pre[0], n[5:0]};
    wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check(rdData == expRd, "R2/R4 readback after first write", rdData, expRd);
    check(loaded == 1'b1, "R2 loaded flag", loaded, 1);
    check(progEnable == 1'b1, "R8 progEnable", progEnable, 1);
    period = (n + 1) * ((pre != 0) ? 8 : 1);
    bad = 0; badCycle = -1; badVal = 0;
    for (int c = 0; c < 4 * period; c++) begin
      if (tickStb != ((c % period) == period - 1)) begin
        if (bad == 0) begin badCycle = c; badVal = tickStb; end
        bad++;
      end
      if (c == 1) begin wrData = ~data; wrEn = 1'b1; end   // late write (R3)
      if (c == 2) wrEn = 1'b0;
      @(negedge clk);
    end
    if (pre != 0)
      check(bad == 0, $sformatf("R6/R7 N=%0d first bad cycle %0d", n, badCycle), badVal, !badVal);
    else if (n == 0)
      check(bad == 0, $sformatf("R9 first bad cycle %0d", badCycle), badVal, !badVal);
    else
      check(bad == 0, $sformatf("R5/R7 N=%0d first bad cycle %0d", n, badCycle), badVal, !badVal);
    check(rdData == expRd, "R3 lock after second write", rdData, expRd);
  endtask

  initial begin
    #(20 * 190000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 2; p++)
      for (int n = 0; n < 64; n++)
        runCfg(p, n);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule